// File: doc/BRIEF.md
# Multiplexed Parallel I/O Controller with Input Deglitching

This block controls a group of chip pins. Each line is either owned by software, acting as an input or as a driven output, or handed over to an on-chip peripheral. When a peripheral owns a line, that peripheral's output value and output enable go to the pad. Pad inputs pass through a synchronizer. Each line can then optionally pass through a two-sample glitch filter. The resulting clean level is offered to the peripheral, to software, and to a change detector.

Every edge of a clean level, rising or falling, sets a sticky change bit. Reading the change register returns those bits and clears them. The interrupt output is high while any pending change bit has its enable bit set. A chip normally places several instances side by side, for example two instances of twelve lines each.

Top module: `pio_ctrl`

## Requirements
- R1: After reset, every configuration register, the level register and the change register read as zero, `pad_oe` is all zero and `irq` is low.
- R2: A write takes effect on the clock edge where `reg_wr` is high. Address 0 holds direction (1 = output), 1 holds output data, 2 holds owner select (1 = peripheral), 3 holds filter enable and 4 holds interrupt enable. Each stores `reg_wdata[NUM_LINES-1:0]`. A read started with `reg_rd` delivers the word on `reg_rdata` after the next edge, with the bits above NUM_LINES read as zero.
- R3: For a line with owner select 0, `pad_oe` follows the direction bit and `pad_out` follows the output data bit.
- R4: For a line with owner select 1, `pad_oe` and `pad_out` follow `periph_oe` and `periph_out`, and that line's direction and output data bits have no effect on the pad.
- R5: With the filter off, a change on `pad_in` set up before edge k appears on `periph_in` after edge k+2 and not before. Address 5 reads the clean level.
- R6: With the filter on, a new level is accepted only after two consecutive equal synchronized samples. The change appears after edge k+3. A one-cycle pulse is dropped. A two-cycle pulse is passed, and both of its edges are reported.
- R7: With the filter off, a one-cycle pulse is passed, and its edges set the line's change bit.
- R8: Each edge of a clean level sets that line's change bit. The bit stays set until address 6 is read. That read returns the bits and clears them, except for bits set again in the same cycle.
- R9: `irq` is high exactly when some change bit is set with its interrupt enable bit set. Pending bits that are masked do not raise it.
- R10: Writes to addresses 5, 6 and 7 change no register, no pending bit and no level.
- R11: `periph_in` carries the clean (synchronized, optionally filtered) level of every line, whatever the owner select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid after the edge following `reg_rd` |
| pad_in | input | NUM_LINES | Raw pad input levels |
| pad_out | output | NUM_LINES | Pad output values |
| pad_oe | output | NUM_LINES | Pad output enables |
| periph_out | input | NUM_LINES | Peripheral output values |
| periph_oe | input | NUM_LINES | Peripheral output enables |
| periph_in | output | NUM_LINES | Clean input levels to the peripheral |
| irq | output | 1 | Change interrupt |

## Verification
The bench sweeps every owner-select pattern of a four-line instance against computed direction, data and peripheral patterns. A swapped pad multiplexer shows up in that sweep. It measures the exact edge on which a pad change reaches `periph_in`, both with and without filtering. One synchronizer stage too few or too many, or a filter that accepts a level after one sample, would move that edge. It sends one-cycle and two-cycle pulses to filtered and unfiltered lines. A filter that lets short pulses through, or that blocks wide ones, leaves the wrong change bits. It also checks that a read clears the change bits, that masked bits stay quiet on `irq`, and that writes to the read-only addresses are ignored.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int PIO_ADDR_W = 3;

   // Register addresses
   typedef enum logic [PIO_ADDR_W-1:0] {
      REG_DIR   = 3'd0,
      REG_DOUT  = 3'd1,
      REG_PSEL  = 3'd2,
      REG_FEN   = 3'd3,
      REG_IEN   = 3'd4,
      REG_LEVEL = 3'd5,
      REG_CHG   = 3'd6
   } pio_reg_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int W      = 12,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[s] <= '0;
            else        pipe_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[s] <= '0;
            else        pipe_q[s] <= pipe_q[s-1];
         end
      end
   end

   assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/pio_glitch_filter.sv
module pio_glitch_filter #(
   parameter int W          = 12,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  logic [W-1:0] fen,
   output logic [W-1:0] lvl,
   output logic [W-1:0] chg
);
   logic [W-1:0] lvl_q, lvl_d, take;

   if (HAS_FILTER) begin : g_filter
      logic [W-1:0] samp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) samp_q <= '0;
         else        samp_q <= din;
      end
      // accept a line when unfiltered, or when two samples agree
      assign take = ~fen | ~(din ^ samp_q);

      // R6
      filter_two_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((lvl_q ^ $past(lvl_q)) & $past(fen) & ($past(din) ^ $past(samp_q))) == '0);
   end else begin : g_bypass
      assign take = '1;
   end

   assign lvl_d = (take & din) | (~take & lvl_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_d;
   end

   assign lvl = lvl_q;
   assign chg = lvl_d ^ lvl_q;
endmodule

// File: rtl/pio_chg_status.sv
module pio_chg_status #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_i,
   input  logic [W-1:0] ien_i,
   output logic [W-1:0] status_o,
   output logic         irq_o
);
   logic [W-1:0] status_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= (clr_i ? '0 : status_q) | set_i;
   end

   assign status_o = status_q;
   assign irq_o    = |(status_q & ien_i);

   // R8
   chg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

   // R8
   chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i == '0) |=> status_q == '0);

   // R9
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (($past(set_i) != '0) || ($past(ien_i) != ien_i)));
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
   import pio_pkg::*;
#(
   parameter int NUM_LINES   = 12,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_FILTER  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [PIO_ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic [NUM_LINES-1:0]  pad_in,
   output logic [NUM_LINES-1:0]  pad_out,
   output logic [NUM_LINES-1:0]  pad_oe,
   input  logic [NUM_LINES-1:0]  periph_out,
   input  logic [NUM_LINES-1:0]  periph_oe,
   output logic [NUM_LINES-1:0]  periph_in,
   output logic                  irq
);
   localparam int N = NUM_LINES;

   if (N < 1 || N > DATA_W) begin : g_bad_width
      $error("pio_ctrl: NUM_LINES must be within 1..DATA_W");
   end

   if (DATA_W > N) begin : g_wide
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^reg_wdata[DATA_W-1:N];
   end

   logic [N-1:0] dir_q, dout_q, psel_q, fen_q, ien_q;
   logic [N-1:0] sync_w, lvl_w, chg_w, status_w;
   logic [DATA_W-1:0] rd_word, rdata_q;
   logic chg_clr;

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         dout_q <= '0;
         psel_q <= '0;
         fen_q  <= '0;
         ien_q  <= '0;
      end else if (reg_wr) begin
         case (pio_reg_e'(reg_addr))
            REG_DIR:  dir_q  <= reg_wdata[N-1:0];
            REG_DOUT: dout_q <= reg_wdata[N-1:0];
            REG_PSEL: psel_q <= reg_wdata[N-1:0];
            REG_FEN:  fen_q  <= reg_wdata[N-1:0];
            REG_IEN:  ien_q  <= reg_wdata[N-1:0];
            default:  ;
         endcase
      end
   end

   // read path
   always_comb begin
      rd_word = '0;
      case (pio_reg_e'(reg_addr))
         REG_DIR:   rd_word[N-1:0] = dir_q;
         REG_DOUT:  rd_word[N-1:0] = dout_q;
         REG_PSEL:  rd_word[N-1:0] = psel_q;
         REG_FEN:   rd_word[N-1:0] = fen_q;
         REG_IEN:   rd_word[N-1:0] = ien_q;
         REG_LEVEL: rd_word[N-1:0] = lvl_w;
         REG_CHG:   rd_word[N-1:0] = status_w;
         default:   rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (reg_rd) rdata_q <= rd_word;
   end

   assign reg_rdata = rdata_q;
   assign chg_clr   = reg_rd && (reg_addr == PIO_ADDR_W'(REG_CHG));

   // input path
   pio_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_w)
   );

   pio_glitch_filter #(.W(N), .HAS_FILTER(HAS_FILTER)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(sync_w), .fen(fen_q),
      .lvl(lvl_w), .chg(chg_w)
   );

   pio_chg_status #(.W(N)) u_chg (
      .clk(clk), .rst_n(rst_n), .set_i(chg_w), .clr_i(chg_clr),
      .ien_i(ien_q), .status_o(status_w), .irq_o(irq)
   );

   assign periph_in = lvl_w;

   // pad ownership multiplexer
   assign pad_oe  = (psel_q & periph_oe)  | (~psel_q & dir_q);
   assign pad_out = (psel_q & periph_out) | (~psel_q & dout_q);

   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == PIO_ADDR_W'(REG_DIR)) |=> dir_q == $past(reg_wdata[N-1:0]));

   // R10
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr >= PIO_ADDR_W'(REG_LEVEL)) |=> $stable(ien_q) && $stable(fen_q));
endmodule

// File: tb/pio_ctrl_bench.sv
module pio_ctrl_bench;
   localparam int N = 4;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [N-1:0] pad_in = '0, pad_out, pad_oe;
   logic [N-1:0] periph_out = '0, periph_oe = '0, periph_in;
   logic irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pio_ctrl #(.NUM_LINES(N), .DATA_W(DW)) u_pio_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in),
      .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 3'(a);
      @(negedge clk);
      reg_rd = 1'b0;
      v = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [N-1:0] d, o, po, pe, ex;

      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1
      chk("R1 pad_oe", 32'(pad_oe), 0);
      chk("R1 irq", 32'(irq), 0);
      for (int a = 0; a < 7; a++) begin
         rd(a, v);
         chk("R1 register", v, 0);
      end

      // R2 write/readback sweep with upper garbage bits
      for (int a = 0; a < 5; a++) begin
         for (int x = 0; x < 16; x++) begin
            wr(a, 32'hFFFF_FFF0 | 32'(x));
            rd(a, v);
            chk("R2 readback", v, 32'(x));
         end
         wr(a, 0);
      end

      // R3 / R4 ownership sweep
      for (int p = 0; p < 16; p++) begin
         d  = 4'((p * 3) & 15);
         o  = 4'((p * 5 + 1) & 15);
         po = 4'((p * 7 + 2) & 15);
         pe = 4'((p * 11 + 3) & 15);
         periph_out = po; periph_oe = pe;
         wr(0, 32'(d)); wr(1, 32'(o)); wr(2, 32'(p));
         ex = 4'(p);
         chk("R3 gpio oe",  32'(pad_oe  & ~ex), 32'(d & ~ex));
         chk("R3 gpio out", 32'(pad_out & ~ex), 32'(o & ~ex));
         chk("R4 periph oe",  32'(pad_oe  & ex), 32'(pe & ex));
         chk("R4 periph out", 32'(pad_out & ex), 32'(po & ex));
      end
      wr(2, 0); wr(1, 0);

      // R10 read-only addresses ignore writes
      wr(0, 32'h9);
      wr(5, 32'hF); wr(6, 32'hF); wr(7, 32'hF);
      rd(0, v); chk("R10 dir kept", v, 32'h9);
      rd(6, v); chk("R10 chg untouched", v, 0);
      rd(5, v); chk("R10 level untouched", v, 0);
      wr(0, 0);

      // R5 / R11 unfiltered latency
      @(negedge clk); pad_in = 4'b0001;
      @(negedge clk);
      @(negedge clk); chk("R5 not before k+2", 32'(periph_in), 0);
      @(negedge clk); chk("R11 after k+2", 32'(periph_in), 32'h1);
      rd(6, v); chk("R8 rise latched", v, 32'h1);
      rd(6, v); chk("R8 cleared by read", v, 0);

      // R6 filtered latency on line 1
      wr(3, 32'b0010);
      @(negedge clk); pad_in = 4'b0011;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk); chk("R6 held at k+2", 32'(periph_in), 32'h1);
      @(negedge clk); chk("R6 accepted at k+3", 32'(periph_in), 32'h3);
      rd(5, v); chk("R5 level register", v, 32'h3);
      rd(6, v); chk("R8 filtered rise", v, 32'h2);

      // R6 / R7 one-cycle pulses on lines 1 (filtered, low pulse) and 2 (unfiltered)
      @(negedge clk); pad_in = 4'b0101;
      @(negedge clk); pad_in = 4'b0011;
      idle(6);
      chk("R6 short pulse dropped", 32'(periph_in), 32'h3);
      rd(6, v); chk("R7 short pulse seen", v, 32'h4);

      // R6 two-cycle low pulse on filtered line 1
      @(negedge clk); pad_in = 4'b0001;
      @(negedge clk);
      @(negedge clk); pad_in = 4'b0011;
      idle(6);
      rd(6, v); chk("R6 wide pulse passed", v, 32'h2);
      chk("R6 level restored", 32'(periph_in), 32'h3);

      // R9 interrupt masking
      wr(4, 32'b0100);
      @(negedge clk); pad_in = 4'b1011;
      @(negedge clk); pad_in = 4'b0011;
      idle(5);
      chk("R9 masked stays low", 32'(irq), 0);
      @(negedge clk); pad_in = 4'b0111;
      @(negedge clk); pad_in = 4'b0011;
      idle(5);
      chk("R9 enabled raises", 32'(irq), 1);
      rd(6, v); chk("R9 pending bits", v, 32'hC);
      chk("R9 low after clear", 32'(irq), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule